// File: doc/BRIEF.md
# Fixed-Priority Nested Interrupt Controller

This block collects up to 32 external interrupt request lines and presents a single request, together with a vector number, to a processor. Each line has a fixed vector equal to its line number plus 32. The vector cannot be changed. A larger vector always wins. A request that outranks everything currently in service preempts it. Lower requests wait until software retires the interrupts above them by writing an end-of-interrupt register. The processor takes a request with a one-cycle acknowledge pulse. That pulse moves the line from pending to in service.

Software uses a word-addressed read/write port. Each line's configuration word holds a mask bit and a trigger-mode bit. These words are reached indirectly. Software first selects a line by writing a select register with a scattered encoding of the line number, and then reads or writes a data window. Three further registers sit beside this window: a global enable, the end-of-interrupt register, and a read-only in-service register. Read data appears one cycle after the read strobe.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `int_req` is low, the in-service register (offset 0x110) reads 0, the enable register (offset 0x0F0) reads 0, and every line's configuration word reads 0x0001_0000 (masked, edge-triggered).
- R2: Writing select value v to offset 0x000 chooses line n when v = ((n & 7) << 1) | ((n & 0x18) << 2). Any other value chooses no line: through the window at offset 0x010, a read returns 0 and a write changes no line.
- R3: The configuration word stores only bit 16 (mask, 1 = masked) and bit 15 (trigger, 1 = level). All other written bits are dropped and read back as 0.
- R4: While requesting, `int_vec` equals 32 plus the number of the highest-numbered unmasked pending line.
- R5: While bit 8 of the enable register is 0, `int_req` stays low. Pending state is kept and is delivered once the bit is set.
- R6: A rising edge on a masked edge-triggered line is remembered. It is requested once the line is unmasked.
- R7: The pending state of an unmasked level-triggered line follows its input while the line is not in service. When the input drops before acknowledge, the request is withdrawn.
- R8: An acknowledge pulse while `int_req` is high sets bit n of the in-service register for the line n being presented. It clears that line's pending state and drops `int_req` for at least one cycle.
- R9: While lines are in service, a request is raised only for a line numbered higher than the highest in-service line.
- R10: A write to offset 0x0B0 clears the highest set in-service bit. The highest remaining eligible pending line is then requested.
- R11: A write to offset 0x0B0 while nothing is in service discards the highest unmasked pending line without delivering it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | NUM_LINES | External request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after `reg_rd` |
| int_req | output | 1 | Interrupt request to the processor |
| int_vec | output | VEC_W | Vector of the presented request |
| int_ack | input | 1 | One-cycle acknowledge from the processor |

## Verification
A wrong pending or in-service bit shows up at the ports as a wrong `int_vec`, or as `int_req` being raised or withheld when it should not be. This appears two clock edges after the stimulus, because the pending register and the request register each add one stage. A corrupted in-service bit can hide for a while, but it becomes visible on the next read of offset 0x110 or on the next request it should or should not block. Select-encoding faults show up as a window read that returns a word when it should return 0, or as a line whose stored word changed when it should not have.

// File: rtl/pic_pkg.sv
package pic_pkg;

  localparam int OFS_SELECT = 'h000;
  localparam int OFS_WINDOW = 'h010;
  localparam int OFS_RETIRE = 'h0B0;
  localparam int OFS_ENABLE = 'h0F0;
  localparam int OFS_INSVC  = 'h110;

  localparam int CFG_MASK_BIT  = 16;
  localparam int CFG_LEVEL_BIT = 15;
  localparam int ENABLE_BIT    = 8;

  typedef enum logic [2:0] {
    RS_NONE, RS_SELECT, RS_WINDOW, RS_RETIRE, RS_ENABLE, RS_INSVC
  } reg_sel_e;

  typedef struct packed {
    logic       ok;
    logic [4:0] line;
  } sel_dec_t;

  // Scattered select encoding: line[2:0] sits at bits 3:1, line[4:3] at bits 6:5.
  function automatic sel_dec_t decode_select(logic [7:0] v);
    sel_dec_t d;
    d.ok   = (v[7] == 1'b0) && (v[4] == 1'b0) && (v[0] == 1'b0);
    d.line = {v[6:5], v[3:1]};
    return d;
  endfunction

endpackage

// File: rtl/pic_cfg.sv
module pic_cfg #(
  parameter int N  = 32,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_line,
  input  logic          wr_mask,
  input  logic          wr_level,
  input  logic [LW-1:0] rd_line,
  output logic [N-1:0]  mask_o,
  output logic [N-1:0]  level_o,
  output logic          rd_mask,
  output logic          rd_level
);

  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        mask_o[g]  <= 1'b1;
        level_o[g] <= 1'b0;
      end else if (wr_en && (wr_line == LW'(g))) begin
        mask_o[g]  <= wr_mask;
        level_o[g] <= wr_level;
      end
    end
  end

  assign rd_mask  = mask_o[rd_line];
  assign rd_level = level_o[rd_line];

endmodule

// File: rtl/pic_pend.sv
module pic_pend #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] mask,
  input  logic [N-1:0] level,
  input  logic [N-1:0] insvc,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);

  logic [N-1:0] irq_d;

  always_ff @(posedge clk) begin
    if (rst) irq_d <= '0;
    else     irq_d <= irq_in;
  end

  for (genvar g = 0; g < N; g++) begin : g_line
    logic rise;
    assign rise = irq_in[g] & ~irq_d[g];

    always_ff @(posedge clk) begin
      if (rst) begin
        pend[g] <= 1'b0;
      end else if (level[g]) begin
        pend[g] <= irq_in[g] & ~mask[g] & ~insvc[g] & ~clr[g];
      end else begin
        pend[g] <= (pend[g] & ~clr[g]) | rise;
      end
    end
  end

endmodule

// File: rtl/pic_arb.sv
module pic_arb #(
  parameter int N        = 32,
  parameter int LW       = 5,
  parameter int VEC_BASE = 32,
  parameter int VEC_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     pend,
  input  logic [N-1:0]     mask,
  input  logic [N-1:0]     insvc,
  input  logic             enable,
  input  logic             ack,
  output logic             req_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [LW-1:0]    sel_o,
  output logic             top_ok,
  output logic [LW-1:0]    top_line
);

  logic [N-1:0]  elig;
  logic          svc_ok;
  logic [LW-1:0] svc_line;
  logic          go;

  assign elig = pend & ~mask;

  always_comb begin
    top_ok   = 1'b0;
    top_line = '0;
    svc_ok   = 1'b0;
    svc_line = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i]) begin
        top_ok   = 1'b1;
        top_line = LW'(i);
      end
      if (insvc[i]) begin
        svc_ok   = 1'b1;
        svc_line = LW'(i);
      end
    end
  end

  assign go = enable && top_ok && (!svc_ok || (top_line > svc_line));

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o <= 1'b0;
      vec_o <= '0;
      sel_o <= '0;
    end else begin
      req_o <= go && !ack;
      if (go && !ack) begin
        sel_o <= top_line;
        vec_o <= VEC_W'(VEC_BASE) + VEC_W'(top_line);
      end
    end
  end

endmodule

// File: rtl/pic_isr.sv
module pic_isr #(
  parameter int N  = 32,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [LW-1:0] set_line,
  input  logic          retire,
  output logic [N-1:0]  insvc
);

  logic [N-1:0] top_mask;

  always_comb begin
    top_mask = '0;
    for (int i = 0; i < N; i++) begin
      if (insvc[i]) top_mask = N'(1) << i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      insvc <= '0;
    end else begin
      insvc <= (insvc & ~(retire ? top_mask : '0)) |
               (set_en ? (N'(1) << set_line) : '0);
    end
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_LINES = 32,
  parameter int VEC_BASE  = 32,
  parameter int VEC_W     = 8,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 int_req,
  output logic [VEC_W-1:0]     int_vec,
  input  logic                 int_ack
);
  import pic_pkg::*;

  localparam int LW = 5;
  localparam int N  = NUM_LINES;

  reg_sel_e      rsel;
  sel_dec_t      sdec;
  logic          sel_ok_q;
  logic [LW-1:0] sel_line_q;
  logic [7:0]    sel_raw_q;
  logic          en_q;
  logic          win_wr;
  logic          retire_fire;
  logic          ack_fire;
  logic [N-1:0]  mask, level, pend, isr_q, clr;
  logic          rd_mask, rd_level;
  logic [LW-1:0] arb_sel, top_line;
  logic          top_ok;

  always_comb begin
    if      (reg_addr == ADDR_W'(OFS_SELECT)) rsel = RS_SELECT;
    else if (reg_addr == ADDR_W'(OFS_WINDOW)) rsel = RS_WINDOW;
    else if (reg_addr == ADDR_W'(OFS_RETIRE)) rsel = RS_RETIRE;
    else if (reg_addr == ADDR_W'(OFS_ENABLE)) rsel = RS_ENABLE;
    else if (reg_addr == ADDR_W'(OFS_INSVC))  rsel = RS_INSVC;
    else                                      rsel = RS_NONE;
  end

  assign sdec = decode_select(reg_wdata[7:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_ok_q   <= 1'b0;
      sel_line_q <= '0;
      sel_raw_q  <= '0;
      en_q       <= 1'b0;
    end else if (reg_wr) begin
      if (rsel == RS_SELECT) begin
        sel_raw_q  <= reg_wdata[7:0];
        sel_line_q <= sdec.line;
        sel_ok_q   <= sdec.ok && (reg_wdata[DATA_W-1:8] == '0) &&
                      (int'(sdec.line) < N);
      end
      if (rsel == RS_ENABLE) en_q <= reg_wdata[ENABLE_BIT];
    end
  end

  assign win_wr      = reg_wr && (rsel == RS_WINDOW) && sel_ok_q;
  assign retire_fire = reg_wr && (rsel == RS_RETIRE);
  assign ack_fire    = int_ack && int_req;

  // Pending clears: the acknowledged line, or the discarded line on a retire with nothing in service.
  assign clr = (ack_fire ? (N'(1) << arb_sel) : '0) |
               ((retire_fire && (isr_q == '0) && top_ok) ? (N'(1) << top_line) : '0);

  pic_cfg #(.N(N), .LW(LW)) u_cfg (
    .clk(clk), .rst(rst),
    .wr_en(win_wr), .wr_line(sel_line_q),
    .wr_mask(reg_wdata[CFG_MASK_BIT]), .wr_level(reg_wdata[CFG_LEVEL_BIT]),
    .rd_line(sel_line_q),
    .mask_o(mask), .level_o(level),
    .rd_mask(rd_mask), .rd_level(rd_level)
  );

  pic_pend #(.N(N)) u_pend (
    .clk(clk), .rst(rst),
    .irq_in(irq_in), .mask(mask), .level(level),
    .insvc(isr_q), .clr(clr), .pend(pend)
  );

  pic_arb #(.N(N), .LW(LW), .VEC_BASE(VEC_BASE), .VEC_W(VEC_W)) u_arb (
    .clk(clk), .rst(rst),
    .pend(pend), .mask(mask), .insvc(isr_q),
    .enable(en_q), .ack(ack_fire),
    .req_o(int_req), .vec_o(int_vec), .sel_o(arb_sel),
    .top_ok(top_ok), .top_line(top_line)
  );

  pic_isr #(.N(N), .LW(LW)) u_isr (
    .clk(clk), .rst(rst),
    .set_en(ack_fire), .set_line(arb_sel),
    .retire(retire_fire), .insvc(isr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      unique case (rsel)
        RS_SELECT: reg_rdata <= DATA_W'(sel_raw_q);
        RS_WINDOW: reg_rdata <= sel_ok_q ?
                                ((DATA_W'(rd_mask) << CFG_MASK_BIT) |
                                 (DATA_W'(rd_level) << CFG_LEVEL_BIT)) : '0;
        RS_ENABLE: reg_rdata <= DATA_W'(en_q) << ENABLE_BIT;
        RS_INSVC:  reg_rdata <= DATA_W'(isr_q);
        default:   reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
  parameter int N        = 32,
  parameter int VEC_BASE = 32,
  parameter int VEC_W    = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             int_req,
  input logic [VEC_W-1:0] int_vec,
  input logic             int_ack,
  input logic             retire_fire,
  input logic             en_q,
  input logic [N-1:0]     isr_q
);

  logic [4:0] vec_line;
  logic [4:0] isr_top;

  assign vec_line = 5'(int_vec - VEC_W'(VEC_BASE));

  always_comb begin
    isr_top = '0;
    for (int i = 0; i < N; i++) if (isr_q[i]) isr_top = 5'(i);
  end

  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    rst |=> (!int_req && (isr_q == '0)));

  assert_gate_by_enable_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(en_q) |-> !int_req);

  assert_vec_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    int_req |-> ((int_vec >= VEC_W'(VEC_BASE)) && (int_vec < VEC_W'(VEC_BASE + N))));

  assert_ack_enters_service_R8: assert property (@(posedge clk) disable iff (rst)
    (int_ack && int_req) |=> (isr_q[$past(vec_line)] && !int_req));

  assert_only_higher_preempts_R9: assert property (@(posedge clk) disable iff (rst)
    (int_req && ($past(isr_q) != '0)) |-> (vec_line > $past(isr_top)));

  assert_retire_drops_one_R10: assert property (@(posedge clk) disable iff (rst)
    (retire_fire && (isr_q != '0) && !(int_ack && int_req)) |=>
      ($countones(isr_q) == $countones($past(isr_q)) - 1));

endmodule

bind prio_irq_ctrl pic_chk #(.N(NUM_LINES), .VEC_BASE(VEC_BASE), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .int_req(int_req), .int_vec(int_vec), .int_ack(int_ack),
  .retire_fire(retire_fire), .en_q(en_q), .isr_q(isr_q)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;

  localparam int NL = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NL-1:0] irq_in = '0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          int_req;
  logic [7:0]    int_vec;
  logic          int_ack = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .int_req(int_req), .int_vec(int_vec), .int_ack(int_ack)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic bus_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] sel_of(int n);
    return 32'(((n & 7) << 1) | ((n & 24) << 2));
  endfunction

  task automatic set_line(int n, logic [31:0] w);
    bus_wr(12'h000, sel_of(n));
    bus_wr(12'h010, w);
  endtask

  task automatic get_line(int n, output logic [31:0] d);
    bus_wr(12'h000, sel_of(n));
    bus_rd(12'h010, d);
  endtask

  task automatic pulse(int n);
    @(negedge clk); irq_in[n] = 1'b1;
    @(negedge clk); irq_in[n] = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); int_ack = 1'b1;
    @(negedge clk); int_ack = 1'b0;
  endtask

  task automatic retire();
    bus_wr(12'h0B0, 32'h0);
  endtask

  initial begin : watchdog
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : stim
    logic [31:0] d;
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(1);

    // R1 reset state
    check("R1 int_req", 32'(int_req), 32'h0);
    bus_rd(12'h110, d); check("R1 insvc", d, 32'h0);
    bus_rd(12'h0F0, d); check("R1 enable", d, 32'h0);
    for (int n = 0; n < NL; n += 9) begin
      get_line(n, d); check("R1 cfg", d, 32'h0001_0000);
    end

    // R2 select encoding sweep over every 8-bit select value
    for (int v = 0; v < 256; v++) begin
      bit ok;
      ok = ((v & 1) == 0) && ((v & 16) == 0) && (v < 128);
      bus_wr(12'h000, 32'(v));
      bus_wr(12'h010, 32'h0000_8000);
      bus_rd(12'h010, d);
      check("R2 window", d, ok ? 32'h0000_8000 : 32'h0);
      bus_wr(12'h010, 32'h0001_0000);
    end
    bus_wr(12'h000, 32'h0000_0102);
    bus_wr(12'h010, 32'h0);
    for (int n = 0; n < NL; n++) begin
      get_line(n, d); check("R2 untouched", d, 32'h0001_0000);
    end

    // R3 only mask and trigger bits stored
    set_line(7, 32'hFFFF_FFFF);
    bus_rd(12'h010, d); check("R3 stored bits", d, 32'h0001_8000);
    set_line(7, 32'h0001_0000);

    // R5 enable gates delivery
    set_line(3, 32'h0);
    pulse(3);
    wait_cyc(3);
    check("R5 gated", 32'(int_req), 32'h0);
    bus_wr(12'h0F0, 32'h100);
    bus_rd(12'h0F0, d); check("R5 enable reads", d, 32'h100);
    wait_cyc(2);
    check("R5 req", 32'(int_req), 32'h1);
    check("R5 vec", 32'(int_vec), 32'd35);

    // R11 retire with nothing in service discards
    retire();
    wait_cyc(3);
    check("R11 discarded", 32'(int_req), 32'h0);
    bus_rd(12'h110, d); check("R11 insvc", d, 32'h0);
    set_line(3, 32'h0001_0000);

    // R4 R8 R10 per-line sweep
    for (int n = 0; n < NL; n++) begin
      set_line(n, 32'h0);
      pulse(n);
      wait_cyc(2);
      check("R4 req", 32'(int_req), 32'h1);
      check("R4 vec", 32'(int_vec), 32'(32 + n));
      ack();
      wait_cyc(1);
      check("R8 req drop", 32'(int_req), 32'h0);
      bus_rd(12'h110, d); check("R8 insvc", d, 32'h1 << n);
      retire();
      bus_rd(12'h110, d); check("R10 insvc clear", d, 32'h0);
      set_line(n, 32'h0001_0000);
    end

    // R9 nesting and R10 release order
    set_line(5, 32'h0);
    set_line(20, 32'h0);
    set_line(25, 32'h0);
    @(negedge clk); irq_in[5] = 1'b1; irq_in[20] = 1'b1;
    @(negedge clk); irq_in = '0;
    wait_cyc(2);
    check("R4 highest wins", 32'(int_vec), 32'd52);
    ack();
    wait_cyc(3);
    check("R9 lower held", 32'(int_req), 32'h0);
    pulse(25);
    wait_cyc(2);
    check("R9 preempt req", 32'(int_req), 32'h1);
    check("R9 preempt vec", 32'(int_vec), 32'd57);
    ack();
    bus_rd(12'h110, d); check("R9 nested insvc", d, (32'h1 << 20) | (32'h1 << 25));
    retire();
    wait_cyc(3);
    bus_rd(12'h110, d); check("R10 top retired", d, 32'h1 << 20);
    check("R10 still held", 32'(int_req), 32'h0);
    retire();
    wait_cyc(2);
    check("R10 next req", 32'(int_req), 32'h1);
    check("R10 next vec", 32'(int_vec), 32'd37);
    ack();
    retire();
    wait_cyc(2);
    bus_rd(12'h110, d); check("R10 empty", d, 32'h0);
    set_line(5, 32'h0001_0000);
    set_line(20, 32'h0001_0000);
    set_line(25, 32'h0001_0000);

    // R6 masked edge remembered
    pulse(9);
    wait_cyc(3);
    check("R6 masked quiet", 32'(int_req), 32'h0);
    set_line(9, 32'h0);
    wait_cyc(2);
    check("R6 req", 32'(int_req), 32'h1);
    check("R6 vec", 32'(int_vec), 32'd41);
    ack();
    retire();
    set_line(9, 32'h0001_0000);

    // R7 level-triggered line
    set_line(12, 32'h0000_8000);
    @(negedge clk); irq_in[12] = 1'b1;
    wait_cyc(3);
    check("R7 level req", 32'(int_req), 32'h1);
    check("R7 level vec", 32'(int_vec), 32'd44);
    @(negedge clk); irq_in[12] = 1'b0;
    wait_cyc(3);
    check("R7 withdrawn", 32'(int_req), 32'h0);
    @(negedge clk); irq_in[12] = 1'b1;
    wait_cyc(3);
    ack();
    wait_cyc(3);
    check("R7 held in service", 32'(int_req), 32'h0);
    bus_rd(12'h110, d); check("R7 insvc", d, 32'h1 << 12);
    @(negedge clk); irq_in[12] = 1'b0;
    retire();
    wait_cyc(3);
    check("R7 after retire", 32'(int_req), 32'h0);
    bus_rd(12'h110, d); check("R7 insvc clear", d, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule